// File: doc/BRIEF.md
# PS/2 Keyboard Scan-Code Receiver

This block listens to a keyboard on the two-wire PS/2 bus and reports key events to the logic behind it. The bus clock and data lines come from the keyboard and are asynchronous to the system clock. The block brings both lines into the system clock domain and filters short pulses off the bus clock. It then shifts in one bit at each falling edge of the bus clock.

Each frame is eleven bits long. When the last bit arrives, the block checks the frame. A good frame yields one byte. The two prefix bytes (E0 for extended keys and F0 for key release) are held as pending flags. Any other byte ends the event: the block gives a one-cycle strobe that carries the scan code together with the release and extended flags, and it clears the flags. A malformed frame gives a one-cycle error strobe and throws away any pending prefix. A frame that stalls part-way is dropped after a programmable quiet time.

Top module: `ps2kb_receiver`

## Requirements
- R1: After synchronous reset, `key_valid` and `frame_err` are low and no prefix is pending.
- R2: A frame is one start bit of 0, eight data bits sent least significant bit first, one odd-parity bit and one stop bit of 1. Each bit is sampled at a falling edge of the bus clock. A good frame whose byte is neither E0 nor F0 raises `key_valid` for exactly one cycle, with `key_code` equal to that byte.
- R3: If the data bits and the parity bit together hold an even number of ones, `frame_err` is high for one cycle and no key event is produced.
- R4: A start bit of 1 or a stop bit of 0 raises `frame_err` for one cycle and produces no key event.
- R5: The byte F0 produces no event by itself. The next scan code is reported with `key_release`=1 and `key_extended`=0.
- R6: The byte E0 produces no event by itself. The next scan code is reported with `key_extended`=1 and `key_release`=0.
- R7: The sequence E0, F0, code is reported as one event with both flags set to 1.
- R8: Both flags clear after each event. A repeated make code is reported again as a new press, with both flags 0.
- R9: A frame error discards any pending prefix, so the next scan code is reported with both flags 0.
- R10: If no bus-clock falling edge arrives for TIMEOUT_CYC system cycles while a frame is partly received, the partial frame is discarded. The next complete frame then decodes correctly.
- R11: A low pulse on the bus clock that lasts fewer than FILT_LEN system cycles is not taken as an edge and does not disturb the frame being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ps2_clk_in | input | 1 | Bus clock line from the keyboard, asynchronous |
| ps2_data_in | input | 1 | Bus data line from the keyboard, asynchronous |
| key_valid | output | 1 | One-cycle strobe that marks a key event |
| key_code | output | 8 | Scan code of the event |
| key_release | output | 1 | Event is a key release (F0 was seen) |
| key_extended | output | 1 | Event is an extended key (E0 was seen) |
| frame_err | output | 1 | One-cycle strobe for a malformed frame |

## Verification
The bench sends plain make codes, repeated make codes, F0 alone, E0 alone and E0 F0 before a code, so each combination of the two flags is seen and a flag cannot leak into the next event. It also sends frames with bad parity, a bad start bit and a bad stop bit, each on its own, to show that every check works alone. One such bad frame follows a pending prefix, to show that the error flushes the prefix. A frame stalled after a few bits, followed by a good frame, tells the watchdog discard apart from bit corruption. A good frame with a short low pulse on the bus clock shows whether the filter rejects glitches, because an accepted glitch would shift every later bit.

// File: rtl/ps2kb_pkg.sv
package ps2kb_pkg;

    localparam int unsigned FRAME_BITS = 11;
    localparam logic [7:0]  PFX_EXT    = 8'hE0;
    localparam logic [7:0]  PFX_BRK    = 8'hF0;

    typedef struct packed {
        logic       brk;
        logic       ext;
        logic [7:0] code;
    } key_evt_t;

    // bit 0 start, bits 8:1 data, bit 9 parity, bit 10 stop
    function automatic logic frame_good(input logic [FRAME_BITS-1:0] f);
        return (~f[0]) & f[10] & (^f[9:1]);
    endfunction

    function automatic logic is_prefix(input logic [7:0] b);
        return (b == PFX_EXT) || (b == PFX_BRK);
    endfunction

endpackage

// File: rtl/ps2kb_sync_filter.sv
module ps2kb_sync_filter #(
    parameter int unsigned FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic line_clk,
    input  logic line_dat,
    output logic fall,
    output logic bit_val
);
    localparam int unsigned CW = $clog2(FILT_LEN + 1);

    logic          clk_s1, clk_s2, dat_s1, dat_s2;
    logic          clk_f;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_s1  <= 1'b1;
            clk_s2  <= 1'b1;
            dat_s1  <= 1'b1;
            dat_s2  <= 1'b1;
            clk_f   <= 1'b1;
            cnt     <= '0;
            fall    <= 1'b0;
            bit_val <= 1'b1;
        end else begin
            clk_s1 <= line_clk;
            clk_s2 <= clk_s1;
            dat_s1 <= line_dat;
            dat_s2 <= dat_s1;
            fall   <= 1'b0;
            if (clk_s2 != clk_f) begin
                if (cnt == CW'(FILT_LEN - 1)) begin
                    clk_f   <= clk_s2;
                    cnt     <= '0;
                    fall    <= clk_f;
                    bit_val <= dat_s2;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                cnt <= '0;
            end
        end
    end

    AST_FALL_LEAVES_LOW: assert property (@(posedge clk) disable iff (rst)
        fall |-> !clk_f); // R11

endmodule

// File: rtl/ps2kb_frame_rx.sv
module ps2kb_frame_rx
    import ps2kb_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 200000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fall,
    input  logic       din,
    output logic       byte_vld,
    output logic [7:0] byte_out,
    output logic       frm_err
);
    localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [3:0]  LAST = 4'(FRAME_BITS - 1);

    logic [FRAME_BITS-2:0] sr;
    logic [3:0]            bit_cnt;
    logic [TW-1:0]         idle_cnt;
    logic [FRAME_BITS-1:0] frame;

    assign frame = {din, sr};

    always_ff @(posedge clk) begin
        if (rst) begin
            sr       <= '0;
            bit_cnt  <= '0;
            idle_cnt <= '0;
            byte_vld <= 1'b0;
            byte_out <= '0;
            frm_err  <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            frm_err  <= 1'b0;
            if (fall) begin
                idle_cnt <= '0;
                if (bit_cnt == LAST) begin
                    bit_cnt <= '0;
                    if (frame_good(frame)) begin
                        byte_vld <= 1'b1;
                        byte_out <= frame[8:1];
                    end else begin
                        frm_err <= 1'b1;
                    end
                end else begin
                    sr      <= {din, sr[FRAME_BITS-2:1]};
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end else if (bit_cnt != '0) begin
                if (idle_cnt == TW'(TIMEOUT_CYC - 1)) begin
                    bit_cnt  <= '0;
                    idle_cnt <= '0;
                end else begin
                    idle_cnt <= idle_cnt + 1'b1;
                end
            end else begin
                idle_cnt <= '0;
            end
        end
    end

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
        (fall && bit_cnt == LAST) |=> (byte_vld != frm_err)); // R2
    AST_ERR_REARMS: assert property (@(posedge clk) disable iff (rst)
        frm_err |-> (bit_cnt == '0)); // R3
    AST_WDOG_BOUND: assert property (@(posedge clk) disable iff (rst)
        idle_cnt < TW'(TIMEOUT_CYC)); // R10

endmodule

// File: rtl/ps2kb_prefix_decode.sv
module ps2kb_prefix_decode
    import ps2kb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       byte_vld,
    input  logic [7:0] byte_in,
    input  logic       frm_err,
    output logic       evt_vld,
    output key_evt_t   evt
);
    logic pend_brk, pend_ext;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_brk <= 1'b0;
            pend_ext <= 1'b0;
            evt_vld  <= 1'b0;
            evt      <= '0;
        end else begin
            evt_vld <= 1'b0;
            if (frm_err) begin
                pend_brk <= 1'b0;
                pend_ext <= 1'b0;
            end else if (byte_vld) begin
                if (byte_in == PFX_EXT) begin
                    pend_ext <= 1'b1;
                end else if (byte_in == PFX_BRK) begin
                    pend_brk <= 1'b1;
                end else begin
                    evt_vld  <= 1'b1;
                    evt.brk  <= pend_brk;
                    evt.ext  <= pend_ext;
                    evt.code <= byte_in;
                    pend_brk <= 1'b0;
                    pend_ext <= 1'b0;
                end
            end
        end
    end

    AST_CODE_GIVES_EVT: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && !is_prefix(byte_in)) |=> evt_vld); // R2
    AST_PREFIX_SILENT: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && is_prefix(byte_in)) |=> !evt_vld); // R5
    AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        evt_vld |-> (!pend_brk && !pend_ext)); // R8
    AST_ERR_FLUSH: assert property (@(posedge clk) disable iff (rst)
        frm_err |=> (!pend_brk && !pend_ext)); // R9

endmodule

// File: rtl/ps2kb_receiver.sv
module ps2kb_receiver
    import ps2kb_pkg::*;
#(
    parameter int unsigned FILT_LEN    = 4,
    parameter int unsigned TIMEOUT_CYC = 200000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ps2_clk_in,
    input  logic       ps2_data_in,
    output logic       key_valid,
    output logic [7:0] key_code,
    output logic       key_release,
    output logic       key_extended,
    output logic       frame_err
);
    logic       fall, bit_val, byte_vld;
    logic [7:0] byte_val;
    key_evt_t   evt;

    ps2kb_sync_filter #(.FILT_LEN(FILT_LEN)) u_sync (
        .clk(clk), .rst(rst), .line_clk(ps2_clk_in), .line_dat(ps2_data_in),
        .fall(fall), .bit_val(bit_val)
    );

    ps2kb_frame_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_rx (
        .clk(clk), .rst(rst), .fall(fall), .din(bit_val),
        .byte_vld(byte_vld), .byte_out(byte_val), .frm_err(frame_err)
    );

    ps2kb_prefix_decode u_dec (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_in(byte_val),
        .frm_err(frame_err), .evt_vld(key_valid), .evt(evt)
    );

    assign key_code     = evt.code;
    assign key_release  = evt.brk;
    assign key_extended = evt.ext;

    AST_EVT_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(key_valid && frame_err)); // R3

endmodule

// File: tb/sim_ps2kb_receiver.sv
module sim_ps2kb_receiver;
    localparam int HALF = 20;

    typedef struct {
        bit         is_err;
        bit         brk;
        bit         ext;
        logic [7:0] code;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ps2c = 1'b1;
    logic       ps2d = 1'b1;
    logic       key_valid, key_release, key_extended, frame_err;
    logic [7:0] key_code;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    exp_t q[$];

    always #5 clk = ~clk;

    ps2kb_receiver #(.FILT_LEN(4), .TIMEOUT_CYC(1000)) u0 (
        .clk(clk), .rst(rst), .ps2_clk_in(ps2c), .ps2_data_in(ps2d),
        .key_valid(key_valid), .key_code(key_code), .key_release(key_release),
        .key_extended(key_extended), .frame_err(frame_err)
    );

    task automatic push_evt(input bit b, input bit e, input logic [7:0] c, input string r);
        exp_t x;
        x.is_err = 1'b0; x.brk = b; x.ext = e; x.code = c; x.req = r;
        q.push_back(x);
    endtask

    task automatic push_err(input string r);
        exp_t x;
        x.is_err = 1'b1; x.brk = 1'b0; x.ext = 1'b0; x.code = '0; x.req = r;
        q.push_back(x);
    endtask

    task automatic send(input logic [7:0] b, input bit bad_start, input bit bad_stop,
                        input bit bad_par, input int nbits, input bit glitch);
        logic [10:0] f;
        f = {~bad_stop, (~^b) ^ bad_par, b, bad_start};
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            ps2d = f[i];
            repeat (HALF / 2) @(negedge clk);
            if (glitch && i == 5) begin
                ps2c = 1'b0;
                repeat (2) @(negedge clk);
                ps2c = 1'b1;
            end
            repeat (HALF / 2) @(negedge clk);
            ps2c = 1'b0;
            repeat (HALF) @(negedge clk);
            ps2c = 1'b1;
        end
        ps2d = 1'b1;
        repeat (3 * HALF) @(negedge clk);
    endtask

    task automatic good(input logic [7:0] b);
        send(b, 1'b0, 1'b0, 1'b0, 11, 1'b0);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && (key_valid || frame_err)) begin
            n_chk++;
            if (q.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected output: valid=%0b err=%0b code=%h expected nothing (R2)",
                         key_valid, frame_err, key_code);
            end else begin
                exp_t x;
                x = q.pop_front();
                if (x.is_err) begin
                    if (!(frame_err && !key_valid)) begin
                        n_bad++;
                        $display("FAIL %s: valid=%0b err=%0b expected err=1 valid=0",
                                 x.req, key_valid, frame_err);
                    end
                end else if (!(key_valid && !frame_err && key_code == x.code &&
                               key_release == x.brk && key_extended == x.ext)) begin
                    n_bad++;
                    $display("FAIL %s: valid=%0b err=%0b code=%h rel=%0b ext=%0b expected code=%h rel=%0b ext=%0b",
                             x.req, key_valid, frame_err, key_code, key_release, key_extended,
                             x.code, x.brk, x.ext);
                end
            end
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_chk++;
        if (key_valid !== 1'b0 || frame_err !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: valid=%b err=%b expected 0 0", key_valid, frame_err);
        end

        push_evt(0, 0, 8'h1C, "R2 plain make");       good(8'h1C);
        push_evt(0, 0, 8'h1C, "R8 repeat make");      good(8'h1C);
        push_evt(1, 0, 8'h1C, "R5 break");            good(8'hF0); good(8'h1C);
        push_evt(0, 1, 8'h75, "R6 extended make");    good(8'hE0); good(8'h75);
        push_evt(1, 1, 8'h75, "R7 extended break");   good(8'hE0); good(8'hF0); good(8'h75);
        push_evt(0, 0, 8'h1C, "R8 flags cleared");    good(8'h1C);
        push_err("R3 bad parity");   send(8'h2A, 1'b0, 1'b0, 1'b1, 11, 1'b0);
        push_err("R4 bad start");    send(8'h2A, 1'b1, 1'b0, 1'b0, 11, 1'b0);
        push_err("R4 bad stop");     send(8'h2A, 1'b0, 1'b1, 1'b0, 11, 1'b0);
        good(8'hE0);
        push_err("R9 error after E0"); send(8'h33, 1'b0, 1'b0, 1'b1, 11, 1'b0);
        push_evt(0, 0, 8'h1C, "R9 extended flag flushed"); good(8'h1C);
        good(8'hF0);
        push_err("R9 error after F0"); send(8'h33, 1'b1, 1'b0, 1'b0, 11, 1'b0);
        push_evt(0, 0, 8'h5A, "R9 release flag flushed"); good(8'h5A);
        send(8'hFF, 1'b0, 1'b0, 1'b0, 4, 1'b0);
        repeat (1500) @(negedge clk);
        push_evt(0, 0, 8'h2B, "R10 after stalled frame"); good(8'h2B);
        push_evt(0, 0, 8'h29, "R11 glitch ignored");
        send(8'h29, 1'b0, 1'b0, 1'b0, 11, 1'b1);

        repeat (200) @(negedge clk);
        n_chk++;
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R2: %0d expected outputs never seen, expected 0", q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, %0d items pending, expected completion", q.size());
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule